// File: doc/BRIEF.md
# Super I/O configuration register controller

This block is the configuration front end of a multi-function I/O controller. A host talks to it through two adjacent byte ports. The even port carries unlock and lock keys and the register index. The odd port reads or writes the register that the index selects. Index values below 0x30 address a small set of global registers. Index values from 0x30 upward address a bank that belongs to one logical device, and global register 7 picks that device.

Writes are shaped by per-register masks. A few registers merge new bits into kept bits. One register is a fixed identification byte. Setting the activate bit of certain devices also turns on that device's power-enable bit in the global power register. The block keeps its defaults across reset, and an input strap picks between two reset values of the index-port base. Downstream address decoders are told about changes through one-cycle strobes. One strobe names the device whose activate, base or interrupt setting changed. A separate strobe marks any change of the power register.

Top module: `sio_cfg_ctrl`

## Requirements
- R1: After reset the block is out of configuration mode (`cfgMode` low), and `rdata` is 0xFF whenever `cs` and `rd` are not both high.
- R2: Out of configuration mode, an index-port write (`addr0`=0) of 0x55 enters configuration mode. In configuration mode, an index-port write of 0xAA leaves it. Any other index-port value written in configuration mode, 0x55 included, becomes the current index, and an index-port read returns it.
- R3: Out of configuration mode, data-port writes and index-port writes other than 0x55 change nothing, and both ports read 0xFF.
- R4: Global register 0x20 always reads 0x47 and ignores writes. Writing 0x02 to global register 0x02 stores it and leaves configuration mode. Any other value written there keeps the block in configuration mode.
- R5: Global write masks are as follows. Registers 0x22 and 0x23 keep the bits of 0x39. Register 0x24 keeps the bits of 0x4E. Registers 0x02, 0x07, 0x26, 0x27 and 0x2B to 0x2F keep the whole byte. Every other global register reads 0x00 (0x20 excepted) and ignores writes.
- R6: Reset values are 0x39 for register 0x22, 0x04 for 0x24 and 0x03 for 0x27. Register 0x26 resets to 0xF0, or to 0x70 when `strapAlt` is high during reset. All other global registers reset to 0x00, except 0x20.
- R7: Banked accesses use the device number held in register 7. If that number is above 8, banked reads return 0xFF and banked writes are ignored. Device 0 registers 0x60 and 0x61 reset to 0x03 and 0xF0. A banked register that is not implemented reads 0x00; 0x90 is one such register.
- R8: Writing a value with bit 0 set to register 0x30 of device 0, 3, 4 or 5 also sets bit 0, 3, 4 or 5 of register 0x22, matching the device number. The same write to any other device leaves 0x22 unchanged.
- R9: Banked write masks are as follows. Device 0: register 0xF0 uses 0xEF, 0xF1 uses 0xFC, and 0xF4 to 0xF7 use 0x5B. Device 4: 0xF0 uses 0x83. Device 5: 0xF0 uses 0x03 and 0xF1 uses 0x7F. Device 7: 0xF0 uses 0x84. Other implemented registers, device 1's 0xF0 among them, store the full byte.
- R10: Device 8 register 0xC0 resets to 0x06. A write to it replaces only the bits of 0x1B and keeps the bits of 0xE4. Device 8 register 0xC1 stores only the low nibble.
- R11: In the cycle after a write changes the stored value of register 0x30, 0x60, 0x61 or 0x70 of a device, `chgStb` is high for one cycle with `chgDev` equal to that device. A write that leaves the value unchanged raises no strobe, and neither does a write to any other register.
- R12: In the cycle after any write changes the value of register 0x22, whether directly or through R8, `pwrStb` is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strapAlt | input | 1 | Selects the alternate reset value of register 0x26 |
| cs | input | 1 | Chip select for both ports |
| addr0 | input | 1 | 0 selects the index port, 1 the data port |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| cfgMode | output | 1 | High while in configuration mode |
| chgStb | output | 1 | One-cycle device-setting change strobe |
| chgDev | output | 4 | Device number carried by `chgStb` |
| pwrStb | output | 1 | One-cycle power-register change strobe |

## Verification
The bench sweeps every global index twice: once to check the reset values, and once writing all ones then all zeros. A mask on the wrong register, or a stored byte that should read zero, shows up there as a wrong read-back. All 256 data values go through the power and 0x24 registers, which exposes a strobe that fires on masked-out bits or misses a real change. Further targeted cases cover:
- a device number beyond the last device, where a design that wrapped or clipped the number would corrupt device 0;
- the activate-forces-power mapping, where a wrong bit or a forced bit for an unmapped device becomes visible;
- the merge write of device 8's 0xC0, where plain masking would clear the kept bits;
- locked-state traffic, where a design that accepted it would show a changed index or register after unlocking.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int GLB_N  = 48;
  localparam int SLOT_N = 18;

  typedef struct packed {
    logic       glbWr;
    logic       bnkWr;
    logic [7:0] idx;
    logic [7:0] data;
  } cfg_cmd_t;

  // register index held by each banked storage slot
  function automatic logic [7:0] slot_addr(int s);
    case (s)
      0:  return 8'h30;
      1:  return 8'h60;
      2:  return 8'h61;
      3:  return 8'h62;
      4:  return 8'h63;
      5:  return 8'h70;
      6:  return 8'h71;
      7:  return 8'h74;
      8:  return 8'hB8;
      9:  return 8'hC0;
      10: return 8'hC1;
      11: return 8'hF0;
      12: return 8'hF1;
      13: return 8'hF2;
      14: return 8'hF4;
      15: return 8'hF5;
      16: return 8'hF6;
      17: return 8'hF7;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] glb_mask(logic [7:0] idx);
    case (idx)
      8'h02, 8'h07, 8'h26, 8'h27,
      8'h2B, 8'h2C, 8'h2D, 8'h2E, 8'h2F: return 8'hFF;
      8'h22, 8'h23:                      return 8'h39;
      8'h24:                             return 8'h4E;
      default:                           return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] glb_default(logic [7:0] idx, logic strapAlt);
    case (idx)
      8'h22:   return 8'h39;
      8'h24:   return 8'h04;
      8'h26:   return strapAlt ? 8'h70 : 8'hF0;
      8'h27:   return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] bank_mask(logic [3:0] dev, logic [7:0] idx);
    logic [7:0] m;
    m = 8'hFF;
    case (dev)
      4'd0: case (idx)
              8'hF0: m = 8'hEF;
              8'hF1: m = 8'hFC;
              8'hF4, 8'hF5, 8'hF6, 8'hF7: m = 8'h5B;
              default: m = 8'hFF;
            endcase
      4'd4: if (idx == 8'hF0) m = 8'h83;
      4'd5: if (idx == 8'hF0) m = 8'h03;
            else if (idx == 8'hF1) m = 8'h7F;
      4'd7: if (idx == 8'hF0) m = 8'h84;
      4'd8: if (idx == 8'hC0) m = 8'h1B;
            else if (idx == 8'hC1) m = 8'h0F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction

  // registers whose unmasked bits survive a write
  function automatic logic bank_keep(logic [3:0] dev, logic [7:0] idx);
    return (dev == 4'd8) && (idx == 8'hC0);
  endfunction

  function automatic logic [7:0] bank_default(logic [3:0] dev, logic [7:0] idx);
    case ({dev, idx})
      {4'd0, 8'h60}: return 8'h03;
      {4'd0, 8'h61}: return 8'hF0;
      {4'd0, 8'h70}: return 8'h06;
      {4'd0, 8'h74}: return 8'h02;
      {4'd0, 8'hF0}: return 8'h0E;
      {4'd0, 8'hF2}: return 8'hFF;
      {4'd3, 8'h60}: return 8'h03;
      {4'd3, 8'h61}: return 8'h78;
      {4'd3, 8'h70}: return 8'h07;
      {4'd3, 8'h74}: return 8'h04;
      {4'd3, 8'hF0}: return 8'h3C;
      {4'd4, 8'h60}: return 8'h03;
      {4'd4, 8'h61}: return 8'hF8;
      {4'd4, 8'h70}: return 8'h04;
      {4'd5, 8'h60}: return 8'h02;
      {4'd5, 8'h61}: return 8'hF8;
      {4'd5, 8'h70}: return 8'h03;
      {4'd5, 8'h74}: return 8'h04;
      {4'd5, 8'hF1}: return 8'h02;
      {4'd5, 8'hF2}: return 8'h03;
      {4'd7, 8'h61}: return 8'h60;
      {4'd7, 8'h70}: return 8'h01;
      {4'd8, 8'hC0}: return 8'h06;
      {4'd8, 8'hC1}: return 8'h03;
      default:       return 8'h00;
    endcase
  endfunction

  // registers that decoders downstream care about
  function automatic logic bank_watched(logic [7:0] idx);
    return (idx == 8'h30) || (idx == 8'h60) || (idx == 8'h61) || (idx == 8'h70);
  endfunction

endpackage

// File: rtl/sio_cfg_seq.sv
module sio_cfg_seq
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] KEY_ENTER = 8'h55,
  parameter logic [7:0] KEY_EXIT  = 8'hAA,
  parameter logic [7:0] EXIT_REG  = 8'h02,
  parameter logic [7:0] EXIT_VAL  = 8'h02
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       addr0,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic       cfgMode,
  output cfg_cmd_t   cmd
);

  logic [7:0] idxQ;
  logic       idxWr;
  logic       datWr;

  assign idxWr = cs && wr && !addr0;
  assign datWr = cs && wr && addr0 && cfgMode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgMode <= 1'b0;
      idxQ    <= 8'h00;
    end else if (idxWr) begin
      if (!cfgMode) begin
        if (wdata == KEY_ENTER) cfgMode <= 1'b1;
      end else if (wdata == KEY_EXIT) begin
        cfgMode <= 1'b0;
      end else begin
        idxQ <= wdata;
      end
    end else if (datWr && idxQ == EXIT_REG && wdata == EXIT_VAL) begin
      cfgMode <= 1'b0;
    end
  end

  always_comb begin
    cmd.glbWr = datWr && (idxQ <  8'(GLB_N));
    cmd.bnkWr = datWr && (idxQ >= 8'(GLB_N));
    cmd.idx   = idxQ;
    cmd.data  = wdata;
  end

endmodule

// File: rtl/sio_cfg_bank.sv
module sio_cfg_bank
  import sio_cfg_pkg::*;
#(
  parameter int         NUM_DEV = 9,
  parameter int         DEV_W   = 4,
  parameter logic [7:0] DEV_ID  = 8'h47
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strapAlt,
  input  cfg_cmd_t         cmd,
  output logic [7:0]       rdVal,
  output logic             chgStb,
  output logic [DEV_W-1:0] chgDev,
  output logic             pwrStb
);

  localparam int          SLOT_W  = $clog2(SLOT_N);
  localparam int          GLB_W   = $clog2(GLB_N);
  localparam logic [7:0]  PWR_REG = 8'h22;
  localparam logic [7:0]  SEL_REG = 8'h07;
  localparam logic [7:0]  ID_REG  = 8'h20;
  localparam logic [7:0]  ACT_REG = 8'h30;

  logic [7:0] glb  [GLB_N];
  logic [7:0] bank [NUM_DEV][SLOT_N];

  logic [7:0]        devSel;
  logic              devOk;
  logic [DEV_W-1:0]  devIx;
  logic              slotHit;
  logic [SLOT_W-1:0] slotIx;
  logic [7:0]        oldVal, bMask, newVal, g22Next;
  logic              bWrite, forcePwr, chgNext;

  assign devSel = glb[GLB_W'(SEL_REG)];
  assign devOk  = devSel < 8'(NUM_DEV);
  assign devIx  = devSel[DEV_W-1:0];

  always_comb begin
    slotHit = 1'b0;
    slotIx  = '0;
    for (int s = 0; s < SLOT_N; s++) begin
      if (cmd.idx == slot_addr(s)) begin
        slotHit = 1'b1;
        slotIx  = SLOT_W'(s);
      end
    end
  end

  assign oldVal = devOk ? bank[devIx][slotIx] : 8'h00;
  assign bMask  = bank_mask(4'(devSel), cmd.idx);
  assign newVal = bank_keep(4'(devSel), cmd.idx) ? ((oldVal & ~bMask) | (cmd.data & bMask))
                                                 : (cmd.data & bMask);
  assign bWrite = cmd.bnkWr && devOk && slotHit;

  // activate bit of a powered device also turns on its power bit
  assign forcePwr = bWrite && (cmd.idx == ACT_REG) && cmd.data[0] &&
                    ((devSel == 8'd0) || (devSel == 8'd3) || (devSel == 8'd4) || (devSel == 8'd5));

  always_comb begin
    g22Next = glb[GLB_W'(PWR_REG)];
    if (cmd.glbWr && cmd.idx == PWR_REG) g22Next = cmd.data & glb_mask(PWR_REG);
    if (forcePwr) g22Next[devSel[2:0]] = 1'b1;
  end

  assign chgNext = bWrite && bank_watched(cmd.idx) && (newVal != oldVal);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < GLB_N; i++) glb[i] <= glb_default(8'(i), strapAlt);
      for (int d = 0; d < NUM_DEV; d++)
        for (int s = 0; s < SLOT_N; s++)
          bank[d][s] <= bank_default(4'(d), slot_addr(s));
      chgStb <= 1'b0;
      chgDev <= '0;
      pwrStb <= 1'b0;
    end else begin
      if (cmd.glbWr) glb[cmd.idx[GLB_W-1:0]] <= cmd.data & glb_mask(cmd.idx);
      glb[GLB_W'(PWR_REG)] <= g22Next;
      if (bWrite) bank[devIx][slotIx] <= newVal;
      chgStb <= chgNext;
      chgDev <= devIx;
      pwrStb <= g22Next != glb[GLB_W'(PWR_REG)];
    end
  end

  always_comb begin
    if (cmd.idx < 8'(GLB_N))
      rdVal = (cmd.idx == ID_REG) ? DEV_ID : glb[cmd.idx[GLB_W-1:0]];
    else if (!devOk)
      rdVal = 8'hFF;
    else if (slotHit)
      rdVal = oldVal;
    else
      rdVal = 8'h00;
  end

endmodule

// File: rtl/sio_cfg_ctrl.sv
module sio_cfg_ctrl
  import sio_cfg_pkg::*;
#(
  parameter int         NUM_DEV = 9,
  parameter logic [7:0] DEV_ID  = 8'h47,
  localparam int        DEV_W   = $clog2(NUM_DEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strapAlt,
  input  logic             cs,
  input  logic             addr0,
  input  logic             rd,
  input  logic             wr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             cfgMode,
  output logic             chgStb,
  output logic [DEV_W-1:0] chgDev,
  output logic             pwrStb
);

  cfg_cmd_t   cmd;
  logic [7:0] rdVal;

  sio_cfg_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs      (cs),
    .addr0   (addr0),
    .wr      (wr),
    .wdata   (wdata),
    .cfgMode (cfgMode),
    .cmd     (cmd)
  );

  sio_cfg_bank #(
    .NUM_DEV (NUM_DEV),
    .DEV_W   (DEV_W),
    .DEV_ID  (DEV_ID)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .strapAlt (strapAlt),
    .cmd      (cmd),
    .rdVal    (rdVal),
    .chgStb   (chgStb),
    .chgDev   (chgDev),
    .pwrStb   (pwrStb)
  );

  assign rdata = (cs && rd && cfgMode) ? (addr0 ? rdVal : cmd.idx) : 8'hFF;

endmodule

// File: rtl/sio_cfg_ctrl_chk.sv
module sio_cfg_ctrl_chk #(
  parameter int NUM_DEV = 9,
  parameter int DEV_W   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs,
  input logic             addr0,
  input logic             rd,
  input logic             wr,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic             cfgMode,
  input logic             chgStb,
  input logic [DEV_W-1:0] chgDev,
  input logic             pwrStb
);

  // R1
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |-> rdata == 8'hFF);

  // R3
  locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgMode && cs && rd) |-> rdata == 8'hFF);

  // R2
  enter_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfgMode && cs && wr && !addr0 && wdata == 8'h55) |=> cfgMode);

  // R2
  exit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgMode && cs && wr && !addr0 && wdata == 8'hAA) |=> !cfgMode);

  // R3
  only_key_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfgMode) |-> $past(cs && wr && !addr0 && wdata == 8'h55));

  // R11
  chg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chgStb |-> $past(cs && wr && addr0 && cfgMode));

  // R11
  chg_dev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chgStb |-> chgDev < DEV_W'(NUM_DEV));

  // R12
  pwr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrStb |-> $past(cs && wr && addr0 && cfgMode));

endmodule

bind sio_cfg_ctrl sio_cfg_ctrl_chk #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_chk (.*);

// File: tb/sio_cfg_ctrl_bench.sv
module sio_cfg_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       strapAlt = 1'b0;
  logic       cs = 1'b0, addr0 = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       cfgMode, chgStb, pwrStb;
  logic [3:0] chgDev;

  int nChk = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  sio_cfg_ctrl u_sio_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .strapAlt(strapAlt), .cs(cs), .addr0(addr0),
    .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .cfgMode(cfgMode),
    .chgStb(chgStb), .chgDev(chgDev), .pwrStb(pwrStb)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic portWr(input logic a, input logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr0 = a; wdata = v;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic portRd(input logic a, output logic [7:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr0 = a;
    #1 v = rdata;
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic setReg(input logic [7:0] i, input logic [7:0] v);
    portWr(1'b0, i);
    portWr(1'b1, v);
  endtask

  task automatic getReg(input logic [7:0] i, output logic [7:0] v);
    portWr(1'b0, i);
    portRd(1'b1, v);
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    strapAlt = strap; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [7:0] expGlbDef(int i, logic strap);
    if (i == 'h20) return 8'h47;
    if (i == 'h22) return 8'h39;
    if (i == 'h24) return 8'h04;
    if (i == 'h26) return strap ? 8'h70 : 8'hF0;
    if (i == 'h27) return 8'h03;
    return 8'h00;
  endfunction

  function automatic logic [7:0] expGlbMask(int i);
    if (i == 'h20) return 8'h47;
    if (i == 'h22 || i == 'h23) return 8'h39;
    if (i == 'h24) return 8'h4E;
    if (i == 'h02 || i == 'h07 || i == 'h26 || i == 'h27 || (i >= 'h2B && i <= 'h2F)) return 8'hFF;
    return 8'h00;
  endfunction

  // device, register, mask triples for the banked mask sweep
  function automatic logic [23:0] maskCase(int k);
    case (k)
      0: return {8'd0, 8'hF0, 8'hEF};
      1: return {8'd0, 8'hF1, 8'hFC};
      2: return {8'd0, 8'hF4, 8'h5B};
      3: return {8'd0, 8'hF5, 8'h5B};
      4: return {8'd0, 8'hF6, 8'h5B};
      5: return {8'd0, 8'hF7, 8'h5B};
      6: return {8'd4, 8'hF0, 8'h83};
      7: return {8'd5, 8'hF0, 8'h03};
      8: return {8'd5, 8'hF1, 8'h7F};
      9: return {8'd7, 8'hF0, 8'h84};
      default: return {8'd1, 8'hF0, 8'hFF};
    endcase
  endfunction

  initial begin
    logic [7:0] v;
    logic [7:0] prev;
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [7:0] prev;
    doReset(1'b0);

    // R1 reset state
    @(negedge clk); #1;
    chk("R1 cfgMode after reset", 8'(cfgMode), 8'h00);
    chk("R1 idle rdata", rdata, 8'hFF);
    // R3 locked reads
    portRd(1'b1, v); chk("R3 locked data read", v, 8'hFF);
    portRd(1'b0, v); chk("R3 locked index read", v, 8'hFF);

    // R2 enter, select, exit; R3 locked writes ignored
    portWr(1'b0, 8'h55); chk("R2 enter key", 8'(cfgMode), 8'h01);
    portWr(1'b0, 8'h23);
    portWr(1'b0, 8'hAA); chk("R2 exit key", 8'(cfgMode), 8'h00);
    portWr(1'b1, 8'h11);
    portWr(1'b0, 8'h24);
    portRd(1'b0, v); chk("R3 locked index read after writes", v, 8'hFF);
    portWr(1'b0, 8'h55);
    portRd(1'b0, v); chk("R3 index unchanged while locked", v, 8'h23);
    portRd(1'b1, v); chk("R3 data unchanged while locked", v, 8'h00);

    // R6 reset values of all globals
    for (int i = 0; i < 48; i++) begin
      getReg(8'(i), v); chk($sformatf("R6 global %02h default", i), v, expGlbDef(i, 1'b0));
    end

    // R5 masks: all ones, then all zeros
    for (int i = 0; i < 48; i++) setReg(8'(i), 8'hFF);
    for (int i = 0; i < 48; i++) begin
      getReg(8'(i), v); chk($sformatf("R5 global %02h ones", i), v, expGlbMask(i));
    end
    for (int i = 0; i < 48; i++) setReg(8'(i), 8'h00);
    for (int i = 0; i < 48; i++) begin
      getReg(8'(i), v); chk($sformatf("R5 global %02h zeros", i), v, (i == 'h20) ? 8'h47 : 8'h00);
    end

    // R12 and R5 sweep of power register
    prev = 8'h00;
    portWr(1'b0, 8'h22);
    for (int x = 0; x < 256; x++) begin
      portWr(1'b1, 8'(x));
      chk("R12 pwrStb on change", 8'(pwrStb), 8'((8'(x) & 8'h39) != prev));
      portRd(1'b1, v); chk("R5 reg22 masked", v, 8'(x) & 8'h39);
      prev = 8'(x) & 8'h39;
    end
    portWr(1'b0, 8'h24);
    for (int x = 0; x < 256; x++) begin
      portWr(1'b1, 8'(x));
      portRd(1'b1, v); chk("R5 reg24 masked", v, 8'(x) & 8'h4E);
    end

    // R2 index read-back
    for (int k = 0; k < 5; k++) begin
      logic [7:0] iv;
      iv = (k == 0) ? 8'h00 : (k == 1) ? 8'h7F : (k == 2) ? 8'h55 : (k == 3) ? 8'hC3 : 8'hFF;
      portWr(1'b0, iv);
      portRd(1'b0, v); chk("R2 index read-back", v, iv);
      chk("R2 still configuring", 8'(cfgMode), 8'h01);
    end

    // R4 identification and exit through register 2
    setReg(8'h20, 8'h00);
    portRd(1'b1, v); chk("R4 id register", v, 8'h47);
    setReg(8'h02, 8'h03); chk("R4 other value keeps mode", 8'(cfgMode), 8'h01);
    setReg(8'h02, 8'h02); chk("R4 exit via reg2", 8'(cfgMode), 8'h00);
    portRd(1'b1, v); chk("R4 read after exit", v, 8'hFF);
    portWr(1'b0, 8'h55);

    // R7 device selection
    setReg(8'h07, 8'h00);
    getReg(8'h60, v); chk("R7 dev0 0x60 default", v, 8'h03);
    getReg(8'h61, v); chk("R7 dev0 0x61 default", v, 8'hF0);
    getReg(8'h90, v); chk("R7 unimplemented banked", v, 8'h00);
    setReg(8'h07, 8'h09);
    setReg(8'h60, 8'h12);
    portRd(1'b1, v); chk("R7 device 9 read", v, 8'hFF);
    setReg(8'h07, 8'h00);
    getReg(8'h60, v); chk("R7 dev0 untouched by device 9", v, 8'h03);
    setReg(8'h07, 8'h08);
    setReg(8'h62, 8'h5A);
    portRd(1'b1, v); chk("R7 device 8 writable", v, 8'h5A);

    // R8 R11 R12 activation
    for (int k = 0; k < 5; k++) begin
      int d;
      logic mapped;
      d = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 3 : (k == 3) ? 4 : 5;
      mapped = (d != 1);
      setReg(8'h22, 8'h00);
      setReg(8'h07, 8'(d));
      setReg(8'h30, 8'h01);
      chk("R11 chgStb on activate", 8'(chgStb), 8'h01);
      chk("R11 chgDev", 8'(chgDev), 8'(d));
      chk("R12 pwrStb on forced bit", 8'(pwrStb), 8'(mapped));
      getReg(8'h22, v); chk("R8 forced power bit", v, mapped ? 8'(1 << d) : 8'h00);
      setReg(8'h30, 8'h01);
      chk("R11 no strobe when unchanged", 8'(chgStb), 8'h00);
      chk("R12 no pwrStb when unchanged", 8'(pwrStb), 8'h00);
      setReg(8'h30, 8'h00);
      chk("R11 strobe on deactivate", 8'(chgStb), 8'h01);
      getReg(8'h22, v); chk("R8 clear keeps power bit", v, mapped ? 8'(1 << d) : 8'h00);
      setReg(8'h74, 8'h55);
      chk("R11 unwatched register", 8'(chgStb), 8'h00);
      setReg(8'h70, 8'h0E);
      chk("R11 strobe on 0x70", 8'(chgStb), 8'h01);
    end

    // R9 banked masks
    for (int k = 0; k < 11; k++) begin
      logic [23:0] mc;
      mc = maskCase(k);
      setReg(8'h07, mc[23:16]);
      setReg(mc[15:8], 8'hFF);
      portRd(1'b1, v); chk($sformatf("R9 dev%0d %02h ones", mc[23:16], mc[15:8]), v, mc[7:0]);
      portWr(1'b1, 8'h00);
      portRd(1'b1, v); chk($sformatf("R9 dev%0d %02h zeros", mc[23:16], mc[15:8]), v, 8'h00);
    end

    // R10 merge register
    setReg(8'h07, 8'h08);
    getReg(8'hC0, v); chk("R10 0xC0 default", v, 8'h06);
    setReg(8'hC0, 8'hFF);
    portRd(1'b1, v); chk("R10 0xC0 merge ones", v, 8'h1F);
    portWr(1'b1, 8'h00);
    portRd(1'b1, v); chk("R10 0xC0 merge zeros", v, 8'h04);
    setReg(8'hC1, 8'hFF);
    portRd(1'b1, v); chk("R10 0xC1 nibble", v, 8'h0F);

    // R6 strap selects alternate base
    doReset(1'b1);
    @(negedge clk); #1;
    chk("R1 cfgMode after second reset", 8'(cfgMode), 8'h00);
    portWr(1'b0, 8'h55);
    getReg(8'h26, v); chk("R6 strap base low", v, 8'h70);
    getReg(8'h27, v); chk("R6 strap base high", v, 8'h03);

    $display("Simulation finished: %0d checks, %0d errors", nChk, nErr);
    $finish;
  end

endmodule